// File: doc/BRIEF.md
# Oversampling Serial Receiver with Centre-Sample Voting

This block turns an asynchronous serial line into received characters. A programmable divisor sets the sample rate. Each bit time holds 16 samples in normal mode or 8 samples in fast mode. The receiver waits on the idle-high line for a falling edge. It then confirms the start bit and assembles a character of 5 to 9 bits, least significant bit first. The value of each bit comes from a 2-of-3 vote over the three samples around the middle of that bit. A short spike on the line therefore cannot flip a bit.

Parity is optional, and even or odd parity can be selected. Only the first stop bit is checked. A transmitter may send one stop bit or two, because the receiver returns to idle in the middle of the first stop bit and treats anything after it as idle line.

Finished characters go into a one-entry holding register. That register carries:
- a ready flag, which a read strobe clears;
- a framing flag and a parity flag, which belong to the held character;
- an overrun flag.

For multi-drop buses there is an address filter. When it is on and characters are 9 bits long, characters whose top bit is zero are dropped.

Top module: `serial_rx_vote`

## Requirements
- R1: One bit time lasts (divisor+1)×16 clock cycles when `fast`=0 and (divisor+1)×8 clock cycles when `fast`=1. Characters sent at that rate are received correctly for every divisor.
- R2: The character length is `nbits_code`+5 bits for codes 0 to 4, and codes 5 to 7 mean 9 bits. Bits arrive least significant first. `rx_data[i]` holds data bit i, and every `rx_data` bit at or above the character length reads zero.
- R3: Every start, data and parity bit takes the majority value of the three samples centred on the middle of the bit: samples 7, 8 and 9 of 16, or samples 3, 4 and 5 of 8. A wrong level on one sample has no effect.
- R4: If the vote on the start bit gives high, the receiver goes back to idle and produces no character. It then waits for the next falling edge.
- R5: When `par_en`=1, a parity bit follows the data bits. `err_parity` is set when the count of ones in the data plus the parity bit is odd (`par_odd`=0) or even (`par_odd`=1). When `par_en`=0 there is no parity bit and `err_parity` stays 0.
- R6: `err_frame` is set for a character whose first stop bit votes low. The data bits of that character are still delivered.
- R7: `rx_ready` is set when a character is stored and stays set until a cycle with `rd`=1. After that cycle it is 0.
- R8: If a character completes while `rx_ready`=1 and `rd`=0, the held character is kept unchanged and `err_overrun` is set. A read clears `err_overrun`.
- R9: When `mpm`=1 and the character length is 9, a character whose ninth bit is 0 is dropped. It does not change `rx_ready`, the data or any flag.
- R10: For 9-bit characters the ninth bit appears on `rx_data[8]`. With `mpm`=1, a character whose ninth bit is 1 (an address) is stored normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, idle high |
| divisor | input | DIV_W | Clocks per sample minus one |
| fast | input | 1 | 1 selects 8 samples per bit, 0 selects 16 |
| nbits_code | input | 3 | Character length minus five (5 to 7 mean nine) |
| par_en | input | 1 | A parity bit is present and checked |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| mpm | input | 1 | Address filter for 9-bit characters |
| rd | input | 1 | Read strobe for the held character |
| rx_data | output | 9 | Held character, unused upper bits zero |
| rx_ready | output | 1 | An unread character is held |
| err_frame | output | 1 | First stop bit of the held character was low |
| err_parity | output | 1 | Parity of the held character was wrong |
| err_overrun | output | 1 | A character was lost while one was unread |

## Verification
The assertions run on every cycle and check the following:
- sample ticks never come on back-to-back cycles unless the divisor is zero;
- the sample phase stays inside its range;
- a rejected start bit returns the receiver to idle;
- storing a character raises ready, and a read lowers it;
- upper data bits are zero after every store;
- an overrun keeps the held data and raises its flag;
- a filtered character leaves ready untouched.

Only the bench scenarios can show that the vote happens at the right sample positions. The bench places a one-sample spike exactly on the middle sample of a start, data or parity bit, and the spike must have no effect. The bench scenarios also show that the parity and framing flags match arithmetic expectations over all lengths, parity modes, both speeds and two divisors.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_RUN  = 1'b1
  } rx_state_e;

  // character length from its code; codes above four select nine bits
  function automatic logic [3:0] bits_of(input logic [2:0] code);
    return (code > 3'd4) ? 4'd9 : (4'(code) + 4'd5);
  endfunction

  function automatic logic majority3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic [8:0] low_mask(input logic [3:0] n);
    logic [9:0] m;
    m = (10'd1 << n) - 10'd1;
    return m[8:0];
  endfunction

  // error when data ones plus parity bit disagree with the chosen sense
  function automatic logic parity_bad(input logic [8:0] d, input logic p,
                                      input logic en, input logic odd);
    return en & ((^d) ^ p ^ odd);
  endfunction

  // frame slot of the first stop bit: start, data, optional parity
  function automatic logic [3:0] stop_slot(input logic [3:0] n, input logic en);
    return n + 4'(en) + 4'd1;
  endfunction

endpackage

// File: rtl/serial_rx_front.sv
module serial_rx_front (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  output logic line_s,
  output logic fall
);
  logic [2:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= 3'b111;
    else        sr <= {sr[1:0], line};
  end

  assign line_s = sr[1];
  assign fall   = sr[2] & ~sr[1];
endmodule

// File: rtl/serial_rx_baud.sv
module serial_rx_baud #(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == divisor);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
#(
  parameter int unsigned OVS_NORM = 16,
  parameter int unsigned OVS_FAST = 8,
  parameter int unsigned PH_W     = $clog2(OVS_NORM)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            line_s,
  input  logic            fall,
  input  logic            tick,
  input  logic            fast,
  input  logic [2:0]      nbits_code,
  input  logic            par_en,
  input  logic            par_odd,
  output logic            busy,
  output logic [PH_W-1:0] phase_o,
  output logic            vote_evt,
  output logic            start_abort,
  output logic            frame_done,
  output logic [8:0]      fr_data,
  output logic            fr_perr,
  output logic            fr_ferr,
  output logic [3:0]      nb_o
);
  localparam logic [PH_W:0] OSN = (PH_W+1)'(OVS_NORM);
  localparam logic [PH_W:0] OSF = (PH_W+1)'(OVS_FAST);

  rx_state_e       st;
  logic [PH_W-1:0] phase;
  logic [3:0]      bit_idx;
  logic [8:0]      shreg;
  logic            v0, v1, par_bit;

  logic [PH_W:0] os, c_mid, c_lo, c_hi, c_last, ph_x;
  logic [3:0]    nb, stop_idx, data_pos;
  logic          vote, is_data, is_par;

  assign os     = fast ? OSF : OSN;
  assign c_mid  = os >> 1;
  assign c_lo   = c_mid - 1'b1;
  assign c_hi   = c_mid + 1'b1;
  assign c_last = os - 1'b1;
  assign ph_x   = {1'b0, phase};

  assign nb       = bits_of(nbits_code);
  assign stop_idx = stop_slot(nb, par_en);
  assign data_pos = bit_idx - 4'd1;
  assign is_data  = (bit_idx != 4'd0) && (bit_idx <= nb);
  assign is_par   = par_en && (bit_idx == nb + 4'd1);

  assign busy        = (st == RX_RUN);
  assign vote        = majority3(v0, v1, line_s);
  assign vote_evt    = busy && tick && (ph_x == c_hi);
  assign start_abort = vote_evt && (bit_idx == 4'd0) && vote;
  assign frame_done  = vote_evt && (bit_idx == stop_idx);

  assign fr_data = shreg;
  assign fr_perr = parity_bad(shreg, par_bit, par_en, par_odd);
  assign fr_ferr = ~vote;
  assign nb_o    = nb;
  assign phase_o = phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= RX_IDLE;
      phase   <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      v0      <= 1'b1;
      v1      <= 1'b1;
      par_bit <= 1'b0;
    end else if (st == RX_IDLE) begin
      if (fall) begin
        st      <= RX_RUN;
        phase   <= '0;
        bit_idx <= '0;
        shreg   <= '0;
        par_bit <= 1'b0;
      end
    end else if (tick) begin
      if (ph_x == c_lo)  v0 <= line_s;
      if (ph_x == c_mid) v1 <= line_s;
      if (vote_evt && is_data) shreg[data_pos] <= vote;
      if (vote_evt && is_par)  par_bit <= vote;
      if (start_abort || frame_done) begin
        st    <= RX_IDLE;
        phase <= '0;
      end else if (ph_x == c_last) begin
        phase   <= '0;
        bit_idx <= bit_idx + 4'd1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end
endmodule

// File: rtl/serial_rx_hold.sv
module serial_rx_hold (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_done,
  input  logic [8:0] fr_data,
  input  logic       fr_perr,
  input  logic       fr_ferr,
  input  logic [3:0] nb,
  input  logic       mpm,
  input  logic       rd,
  output logic [8:0] rx_data,
  output logic       rx_ready,
  output logic       err_frame,
  output logic       err_parity,
  output logic       err_overrun,
  output logic       accept,
  output logic       load
);
  logic ovr_evt;

  assign accept  = !(mpm && (nb == 4'd9) && !fr_data[8]);
  assign load    = frame_done && accept && (!rx_ready || rd);
  assign ovr_evt = frame_done && accept && rx_ready && !rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data     <= '0;
      rx_ready    <= 1'b0;
      err_frame   <= 1'b0;
      err_parity  <= 1'b0;
      err_overrun <= 1'b0;
    end else if (load) begin
      rx_data     <= fr_data;
      rx_ready    <= 1'b1;
      err_frame   <= fr_ferr;
      err_parity  <= fr_perr;
      err_overrun <= 1'b0;
    end else if (ovr_evt) begin
      err_overrun <= 1'b1;
    end else if (rd && rx_ready) begin
      rx_ready    <= 1'b0;
      err_overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_rx_vote.sv
module serial_rx_vote #(
  parameter int unsigned DIV_W    = 12,
  parameter int unsigned OVS_NORM = 16,
  parameter int unsigned OVS_FAST = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd,
  input  logic [DIV_W-1:0] divisor,
  input  logic             fast,
  input  logic [2:0]       nbits_code,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             mpm,
  input  logic             rd,
  output logic [8:0]       rx_data,
  output logic             rx_ready,
  output logic             err_frame,
  output logic             err_parity,
  output logic             err_overrun
);
  localparam int unsigned PH_W = $clog2(OVS_NORM);

  logic            line_s, fall, baud_tick, is_busy;
  logic [PH_W-1:0] phase;
  logic            vote_evt, start_abort, frame_done;
  logic [8:0]      fr_data;
  logic            fr_perr, fr_ferr, frame_accept, buf_load;
  logic [3:0]      nb;

  serial_rx_front u_front (
    .clk(clk), .rst_n(rst_n), .line(rxd), .line_s(line_s), .fall(fall)
  );

  serial_rx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(is_busy), .divisor(divisor), .tick(baud_tick)
  );

  serial_rx_frame #(.OVS_NORM(OVS_NORM), .OVS_FAST(OVS_FAST), .PH_W(PH_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .line_s(line_s), .fall(fall), .tick(baud_tick),
    .fast(fast), .nbits_code(nbits_code), .par_en(par_en), .par_odd(par_odd),
    .busy(is_busy), .phase_o(phase), .vote_evt(vote_evt),
    .start_abort(start_abort), .frame_done(frame_done), .fr_data(fr_data),
    .fr_perr(fr_perr), .fr_ferr(fr_ferr), .nb_o(nb)
  );

  serial_rx_hold u_hold (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .fr_data(fr_data),
    .fr_perr(fr_perr), .fr_ferr(fr_ferr), .nb(nb), .mpm(mpm), .rd(rd),
    .rx_data(rx_data), .rx_ready(rx_ready), .err_frame(err_frame),
    .err_parity(err_parity), .err_overrun(err_overrun),
    .accept(frame_accept), .load(buf_load)
  );
endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk
  import serial_rx_pkg::*;
#(
  parameter int unsigned DIV_W    = 12,
  parameter int unsigned OVS_NORM = 16,
  parameter int unsigned OVS_FAST = 8,
  parameter int unsigned PH_W     = $clog2(OVS_NORM)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] divisor,
  input logic             fast,
  input logic             mpm,
  input logic             rd,
  input logic [8:0]       rx_data,
  input logic             rx_ready,
  input logic             err_frame,
  input logic             err_overrun,
  input logic             baud_tick,
  input logic             is_busy,
  input logic [PH_W-1:0]  phase,
  input logic             start_abort,
  input logic             frame_done,
  input logic [8:0]       fr_data,
  input logic             fr_ferr,
  input logic             frame_accept,
  input logic             buf_load,
  input logic [3:0]       nb
);
  logic [PH_W:0] os_lim;
  assign os_lim = fast ? (PH_W+1)'(OVS_FAST) : (PH_W+1)'(OVS_NORM);

  // R1: samples are spaced divisor+1 clocks apart
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick && (divisor != '0) |=> !baud_tick);

  // R1: sample phase never leaves the current oversampling range
  p_phase_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    is_busy |-> ({1'b0, phase} < os_lim));

  // R4: a start bit voted high drops the receiver back to idle
  p_abort_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_abort |=> !is_busy);

  // R2: bits above the character length are zero after a store
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    buf_load |=> ((rx_data & ~low_mask(nb)) == 9'd0));

  // R7: a store raises ready
  p_ready_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_load |=> rx_ready);

  // R7: a read without a simultaneous completion lowers ready
  p_ready_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd && rx_ready && !frame_done |=> !rx_ready);

  // R8: overrun keeps the held data and raises its flag
  p_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && frame_accept && rx_ready && !rd |=> err_overrun && $stable(rx_data));

  // R6: a low first stop bit is reported with the stored character
  p_frame_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_load && fr_ferr |=> err_frame);

  // R9: a filtered data character does not raise ready
  p_mpm_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && mpm && (nb == 4'd9) && !fr_data[8] && !rx_ready |=> !rx_ready);
endmodule

bind serial_rx_vote serial_rx_chk #(
  .DIV_W(DIV_W), .OVS_NORM(OVS_NORM), .OVS_FAST(OVS_FAST), .PH_W(PH_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .divisor(divisor), .fast(fast), .mpm(mpm), .rd(rd),
  .rx_data(rx_data), .rx_ready(rx_ready), .err_frame(err_frame),
  .err_overrun(err_overrun), .baud_tick(baud_tick), .is_busy(is_busy),
  .phase(phase), .start_abort(start_abort), .frame_done(frame_done),
  .fr_data(fr_data), .fr_ferr(fr_ferr), .frame_accept(frame_accept),
  .buf_load(buf_load), .nb(nb)
);

// File: tb/tb_serial_rx_vote.sv
`timescale 1ns/1ps
module tb_serial_rx_vote;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, rxd, fast, par_en, par_odd, mpm, rd;
  logic [11:0] divisor;
  logic [2:0]  nbits_code;
  logic [8:0]  rx_data;
  logic        rx_ready, err_frame, err_parity, err_overrun;

  serial_rx_vote dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .divisor(divisor), .fast(fast),
    .nbits_code(nbits_code), .par_en(par_en), .par_odd(par_odd), .mpm(mpm),
    .rd(rd), .rx_data(rx_data), .rx_ready(rx_ready), .err_frame(err_frame),
    .err_parity(err_parity), .err_overrun(err_overrun)
  );

  int n_chk = 0;
  int n_err = 0;
  int u = 1, bitp = 16, gpos = 9;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench restatement of the bit time: (divisor+1) * samples per bit
  task automatic set_rate(input int dv, input bit f);
    int os;
    divisor = 12'(dv);
    fast    = f;
    os      = f ? 8 : 16;
    u       = dv + 1;
    bitp    = u * os;
    gpos    = (os / 2 + 1) * u;   // line slot read by the middle centre sample
  endtask

  task automatic drive_bit(input logic v, input bit g);
    for (int c = 0; c < bitp; c++) begin
      rxd = (g && c == gpos) ? ~v : v;
      @(negedge clk);
    end
  endtask

  task automatic send(input logic [8:0] val, input int nb, input bit pen, input bit podd,
                      input bit badp, input bit stopv, input int gb);
    logic p;
    p = 1'b0;
    for (int i = 0; i < nb; i++) p ^= val[i];
    p = p ^ podd ^ badp;
    drive_bit(1'b0, gb == 0);
    for (int i = 0; i < nb; i++) drive_bit(val[i], gb == i + 1);
    if (pen) drive_bit(p, gb == nb + 1);
    drive_bit(stopv, 1'b0);
    rxd = 1'b1;
    repeat (2 * u + 2) @(negedge clk);
  endtask

  task automatic do_read();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  function automatic int maskv(input int nb);
    return (1 << nb) - 1;
  endfunction

  initial begin
    rxd = 1'b1; rd = 1'b0; mpm = 1'b0; par_en = 1'b0; par_odd = 1'b0;
    nbits_code = 3'd3; rst_n = 1'b0;
    set_rate(0, 1'b0);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rx_ready == 1'b0, "R7 reset ready", int'(rx_ready), 0);
    check({err_frame, err_parity, err_overrun} == 3'b000, "R6 reset flags",
          int'({err_frame, err_parity, err_overrun}), 0);
    check(rx_data == 9'd0, "R2 reset data", int'(rx_data), 0);

    // sweep: both speeds, two divisors, every length and parity mode, spikes
    begin
      int idx;
      idx = 0;
      for (int f = 0; f < 2; f++) begin
        for (int dsel = 0; dsel < 2; dsel++) begin
          set_rate(dsel * 3, f[0]);
          for (int nb = 5; nb <= 9; nb++) begin
            for (int pm = 0; pm < 3; pm++) begin
              for (int k = 0; k < 2; k++) begin
                logic [8:0] val;
                int gb;
                bit pen, podd;
                pen  = (pm != 0);
                podd = (pm == 2);
                val  = 9'((idx * 73 + 29) & 9'h1FF);
                gb   = idx % (nb + 1 + int'(pen));
                nbits_code = 3'(nb - 5);
                par_en = pen; par_odd = podd;
                send(val, nb, pen, podd, 1'b0, 1'b1, gb);
                check(rx_ready == 1'b1, "R1 ready after frame", int'(rx_ready), 1);
                check(int'(rx_data) == (int'(val) & maskv(nb)), "R2 R3 data under spike",
                      int'(rx_data), int'(val) & maskv(nb));
                check(err_parity == 1'b0, "R5 no parity error", int'(err_parity), 0);
                check(err_frame == 1'b0, "R6 no frame error", int'(err_frame), 0);
                do_read();
                check(rx_ready == 1'b0, "R7 read clears ready", int'(rx_ready), 1'b0);
                idx++;
              end
            end
          end
        end
      end
    end

    // directed cases at divisor 1, normal speed, 8 bits
    set_rate(1, 1'b0);
    nbits_code = 3'd3; par_en = 1'b1; par_odd = 1'b0;

    // R4: a two-clock low pulse is not a start bit
    rxd = 1'b0; repeat (2) @(negedge clk); rxd = 1'b1;
    repeat (bitp * 12) @(negedge clk);
    check(rx_ready == 1'b0, "R4 false start ignored", int'(rx_ready), 0);
    send(9'h0A5, 8, 1'b1, 1'b0, 1'b0, 1'b1, -1);
    check(rx_ready == 1'b1 && rx_data == 9'h0A5, "R4 resync after false start",
          int'(rx_data), 'h0A5);
    do_read();

    // R5: corrupted parity, even and odd
    send(9'h03C, 8, 1'b1, 1'b0, 1'b1, 1'b1, -1);
    check(err_parity == 1'b1, "R5 even parity error", int'(err_parity), 1);
    do_read();
    par_odd = 1'b1;
    send(9'h081, 8, 1'b1, 1'b1, 1'b1, 1'b1, -1);
    check(err_parity == 1'b1, "R5 odd parity error", int'(err_parity), 1);
    do_read();
    send(9'h081, 8, 1'b1, 1'b1, 1'b0, 1'b1, -1);
    check(err_parity == 1'b0, "R5 odd parity good", int'(err_parity), 0);
    do_read();

    // R6: low stop bit, data still delivered
    send(9'h05A, 8, 1'b1, 1'b1, 1'b0, 1'b0, -1);
    check(err_frame == 1'b1, "R6 frame error", int'(err_frame), 1);
    check(rx_data == 9'h05A, "R6 data kept", int'(rx_data), 'h05A);
    do_read();
    send(9'h011, 8, 1'b1, 1'b1, 1'b0, 1'b1, -1);
    check(err_frame == 1'b0, "R6 frame error cleared by good frame", int'(err_frame), 0);

    // R7 / R8: ready persists, second frame overruns
    repeat (bitp * 3) @(negedge clk);
    check(rx_ready == 1'b1, "R7 ready holds until read", int'(rx_ready), 1);
    send(9'h0EE, 8, 1'b1, 1'b1, 1'b0, 1'b1, -1);
    check(err_overrun == 1'b1, "R8 overrun set", int'(err_overrun), 1);
    check(rx_data == 9'h011, "R8 held data kept", int'(rx_data), 'h011);
    do_read();
    check(err_overrun == 1'b0 && rx_ready == 1'b0, "R8 read clears overrun",
          int'({err_overrun, rx_ready}), 0);

    // R9 / R10: address filter with nine-bit characters
    nbits_code = 3'd4; par_en = 1'b0; mpm = 1'b1;
    send(9'h07F, 9, 1'b0, 1'b0, 1'b0, 1'b1, -1);
    check(rx_ready == 1'b0, "R9 data character dropped", int'(rx_ready), 0);
    check(rx_data == 9'h011, "R9 held data untouched", int'(rx_data), 'h011);
    send(9'h142, 9, 1'b0, 1'b0, 1'b0, 1'b1, 3);
    check(rx_ready == 1'b1 && rx_data == 9'h142, "R10 address character stored",
          int'(rx_data), 'h142);
    do_read();
    mpm = 1'b0;
    send(9'h07F, 9, 1'b0, 1'b0, 1'b0, 1'b1, -1);
    check(rx_ready == 1'b1 && rx_data == 9'h07F, "R10 ninth bit zero without filter",
          int'(rx_data), 'h07F);
    do_read();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL R7 watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule